// File: doc/BRIEF.md
# Sigma-Delta Pulse-Density Full-Bridge Modulator

This block turns a stream of signed 24-bit audio samples into a single-bit pulse-density pattern. It drives the four gates of a full-bridge class-D output stage directly. An upstream stage supplies samples that are already upsampled to the modulator rate, together with a valid strobe. Each pulse on the modulator clock enable advances a saturating sigma-delta loop by one step. The loop order is a build parameter from 1 to 4. The default is a second-order loop with unit gains. Orders above two scale the later stages down by a fixed shift.

Each loop output bit selects one diagonal pair of the bridge. A 1 closes the positive diagonal, which is the high-side switch of one leg and the low-side switch of the other. A 0 closes the negative diagonal. Near full scale the loop settles into long runs of a single state with no switching at all. This moves switching events away from the high-current parts of the waveform.

Dead-time is left to the external gate drivers. Interpolation and output filtering happen outside the block.

Top module: `pdm_bridge_mod`

## Requirements
- R1: `smp_in` is taken as a signed two's-complement 24-bit value. It is captured only in a cycle where `smp_vld` is high. In every other cycle the last captured sample keeps feeding the loop.
- R2: While `run` is high, each cycle with `mod_tick` high produces exactly one loop bit. That bit reaches the gate outputs two clock edges later. Without ticks the gate outputs stay unchanged.
- R3: With a held input x, the fraction of 1 bits over 1024 ticks equals (x + 2^23) / 2^24 within 12 counts. This holds for x in the range -2^22 to +2^22.
- R4: A loop bit of 1 drives `gate_p_hs` and `gate_p_ls` high and `gate_n_hs` and `gate_n_ls` low. A loop bit of 0 drives the opposite. While running, the two diagonal pairs are never on together.
- R5: With x = 2^23-1, after 64 settling ticks the output is 1 on every tick with no transitions over 512 ticks. With x = -2^23 it is 0 on every tick.
- R6: Every integrator is IW bits wide, 32 by default. Each one saturates at its signed limits instead of wrapping.
- R7: When `run` is low, all four gate outputs are low from the next clock edge onward.
- R8: A synchronous `rst` drives all gates low and clears the held sample, all integrators and the feedback bit. The same input after each reset therefore yields the same bit sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the loop and the gate outputs |
| mod_tick | input | 1 | Clock enable, one loop step per high cycle |
| smp_vld | input | 1 | Strobe that captures `smp_in` |
| smp_in | input | 24 | Signed audio sample |
| gate_p_hs | output | 1 | High-side gate of the positive diagonal |
| gate_p_ls | output | 1 | Low-side gate of the positive diagonal |
| gate_n_hs | output | 1 | High-side gate of the negative diagonal |
| gate_n_ls | output | 1 | Low-side gate of the negative diagonal |

## Verification
Some properties are checked on every cycle. These are the diagonal-pair exclusivity, gates dropping to low after `run` falls, gates holding between loop bits, the sample holding without a strobe, loop bits only following a tick, and integrators pinning at their limits on overload. Other behaviours only the directed scenarios can show. These are the pulse density against the input level, the switch-free runs at both full-scale ends, and the bit sequence repeating identically after each reset.

// File: rtl/pdm_bridge_pkg.sv
package pdm_bridge_pkg;

  typedef struct packed {
    logic p_hs;
    logic p_ls;
    logic n_hs;
    logic n_ls;
  } gate_set_t;

  // Clamp a wide signed value into a w-bit signed range.
  function automatic logic signed [63:0] sat_clamp(input logic signed [63:0] v,
                                                   input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Feedback level fed back into the loop for a given output bit.
  function automatic logic signed [63:0] fb_level(input logic b, input int unsigned dw);
    return b ? (64'sd1 <<< (dw - 1)) : -(64'sd1 <<< (dw - 1));
  endfunction

  // Bit 1 closes the positive diagonal, bit 0 the negative one.
  function automatic gate_set_t bit_to_gates(input logic b);
    gate_set_t g;
    g.p_hs = b;
    g.p_ls = b;
    g.n_hs = ~b;
    g.n_ls = ~b;
    return g;
  endfunction

endpackage

// File: rtl/pdm_sample_hold.sv
module pdm_sample_hold #(
  parameter int DW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_in,
  output logic signed [DW-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (smp_vld) held <= smp_in;
  end
endmodule

// File: rtl/pdm_sd_loop.sv
module pdm_sd_loop
  import pdm_bridge_pkg::*;
#(
  parameter int DW    = 24,
  parameter int IW    = 32,
  parameter int ORDER = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [DW-1:0] smp,
  output logic                 bit_q,
  output logic                 bit_vld,
  output logic signed [IW-1:0] acc_last,
  output logic                 sat_hi,
  output logic                 sat_lo
);
  localparam int SH = (ORDER > 2) ? 2 : 0;
  localparam logic signed [63:0] MAXV = (64'sd1 <<< (IW - 1)) - 64'sd1;
  localparam logic signed [63:0] MINV = -MAXV - 64'sd1;

  logic signed [63:0] fb;
  assign fb = fb_level(bit_q, DW);

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic signed [63:0]   stg_in;
    logic signed [63:0]   stg_fb;
    logic signed [63:0]   raw;
    logic signed [IW-1:0] acc_d;
    logic signed [IW-1:0] acc_q;

    if (k == 0) begin : g_first
      assign stg_in = 64'(smp);
      assign stg_fb = fb;
    end else begin : g_next
      assign stg_in = 64'(g_stage[k-1].acc_d) >>> SH;
      assign stg_fb = fb >>> SH;
    end

    always_comb begin
      raw   = 64'(acc_q) + stg_in - stg_fb;
      acc_d = IW'(sat_clamp(raw, IW));
    end

    always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (step) acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q   <= 1'b0;
      bit_vld <= 1'b0;
    end else begin
      bit_vld <= step;
      if (step) bit_q <= (g_stage[ORDER-1].acc_d >= 0);
    end
  end

  assign acc_last = g_stage[ORDER-1].acc_q;
  assign sat_hi   = g_stage[ORDER-1].raw > MAXV;
  assign sat_lo   = g_stage[ORDER-1].raw < MINV;
endmodule

// File: rtl/pdm_bridge_map.sv
module pdm_bridge_map
  import pdm_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      bit_vld,
  input  logic      bit_q,
  output gate_set_t gates
);
  always_ff @(posedge clk) begin
    if (rst || !run)  gates <= '0;
    else if (bit_vld) gates <= bit_to_gates(bit_q);
  end
endmodule

// File: rtl/pdm_bridge_mod.sv
module pdm_bridge_mod
  import pdm_bridge_pkg::*;
#(
  parameter int DW    = 24,
  parameter int IW    = 32,
  parameter int ORDER = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          mod_tick,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_in,
  output logic          gate_p_hs,
  output logic          gate_p_ls,
  output logic          gate_n_hs,
  output logic          gate_n_ls
);
  logic signed [DW-1:0] held_smp;
  logic                 loop_step;
  logic                 loop_bit;
  logic                 loop_vld;
  logic signed [IW-1:0] acc_last;
  logic                 sat_hi;
  logic                 sat_lo;
  gate_set_t            gate_q;

  assign loop_step = mod_tick & run;

  pdm_sample_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in), .held(held_smp)
  );

  pdm_sd_loop #(.DW(DW), .IW(IW), .ORDER(ORDER)) u_loop (
    .clk(clk), .rst(rst), .step(loop_step), .smp(held_smp),
    .bit_q(loop_bit), .bit_vld(loop_vld), .acc_last(acc_last),
    .sat_hi(sat_hi), .sat_lo(sat_lo)
  );

  pdm_bridge_map u_map (
    .clk(clk), .rst(rst), .run(run), .bit_vld(loop_vld), .bit_q(loop_bit), .gates(gate_q)
  );

  assign gate_p_hs = gate_q.p_hs;
  assign gate_p_ls = gate_q.p_ls;
  assign gate_n_hs = gate_q.n_hs;
  assign gate_n_ls = gate_q.n_ls;
endmodule

// File: rtl/pdm_bridge_chk.sv
module pdm_bridge_chk
  import pdm_bridge_pkg::*;
#(
  parameter int DW = 24,
  parameter int IW = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run,
  input logic                 smp_vld,
  input logic signed [DW-1:0] held,
  input logic                 step,
  input logic                 loop_vld,
  input logic signed [IW-1:0] acc_last,
  input logic                 sat_hi,
  input logic                 sat_lo,
  input gate_set_t            gates
);
  localparam logic signed [IW-1:0] MAXV = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = {1'b1, {(IW-1){1'b0}}};

  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (rst) !smp_vld |=> $stable(held)); // R1
  AST_BIT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) loop_vld |-> $past(step)); // R2
  AST_GATES_HOLD: assert property (@(posedge clk) disable iff (rst) (run && !loop_vld) |=> $stable(gates)); // R2
  AST_DIAG_PAIRS: assert property (@(posedge clk) disable iff (rst) (|gates) |-> (gates.p_hs == gates.p_ls && gates.n_hs == gates.n_ls && gates.p_hs != gates.n_hs)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (step && sat_hi) |=> acc_last == MAXV); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) (step && sat_lo) |=> acc_last == MINV); // R6
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst) !run |=> gates == '0); // R7
endmodule

bind pdm_bridge_mod pdm_bridge_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .smp_vld(smp_vld), .held(held_smp),
  .step(loop_step), .loop_vld(loop_vld), .acc_last(acc_last),
  .sat_hi(sat_hi), .sat_lo(sat_lo), .gates(gate_q)
);

// File: tb/test_pdm_bridge_mod.sv
module test_pdm_bridge_mod;
  localparam int DW = 24;
  localparam int FS = 1 << 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic mod_tick = 1'b0;
  logic smp_vld = 1'b0;
  logic [DW-1:0] smp_in = '0;
  logic gate_p_hs, gate_p_ls, gate_n_hs, gate_n_ls;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pdm_bridge_mod i_pdm_bridge_mod (
    .clk(clk), .rst(rst), .run(run), .mod_tick(mod_tick), .smp_vld(smp_vld),
    .smp_in(smp_in), .gate_p_hs(gate_p_hs), .gate_p_ls(gate_p_ls),
    .gate_n_hs(gate_n_hs), .gate_n_ls(gate_n_ls)
  );

  function automatic logic [3:0] gates();
    return {gate_p_hs, gate_p_ls, gate_n_hs, gate_n_ls};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; mod_tick = 1'b0; smp_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk(gates() == 4'b0, "R8 gates low in reset", gates(), 0);
    rst = 1'b0;
  endtask

  task automatic load(input int x);
    smp_in = DW'(x); smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic count_bits(input int n, output int ones, output int trans, output int perr);
    logic prev;
    ones = 0; trans = 0; perr = 0;
    prev = gate_p_hs;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate_p_hs) ones++;
      if (gate_p_hs != prev) trans++;
      prev = gate_p_hs;
      if (!(gate_p_hs == gate_p_ls && gate_n_hs == gate_n_ls && gate_p_hs != gate_n_hs)) perr++;
    end
  endtask

  task automatic start_run(input int x);
    do_reset();
    load(x);
    run = 1'b1; mod_tick = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic t_density(input int x);
    int ones, trans, perr, expv, diff;
    start_run(x);
    count_bits(1024, ones, trans, perr);
    expv = int'((longint'(x) + FS) * 1024 / (2 * FS));
    diff = ones - expv;
    if (diff < 0) diff = -diff;
    chk(diff <= 12, "R3 density", ones, expv);
    chk(perr == 0, "R4 diagonal pairs", perr, 0);
  endtask

  task automatic t_fullscale();
    int ones, trans, perr;
    start_run(FS - 1);
    count_bits(512, ones, trans, perr);
    chk(ones == 512, "R5 positive full scale ones", ones, 512);
    chk(trans == 0, "R5 positive full scale transitions", trans, 0);
    chk(perr == 0, "R4 pairs at full scale", perr, 0);
    start_run(-FS);
    count_bits(512, ones, trans, perr);
    chk(ones == 0, "R5 negative full scale ones", ones, 0);
    chk(trans == 0, "R5 negative full scale transitions", trans, 0);
  endtask

  task automatic t_hold();
    int ones, trans, perr;
    do_reset();
    load(FS / 2);
    smp_in = DW'(-FS / 2);
    run = 1'b1; mod_tick = 1'b1;
    repeat (64) @(negedge clk);
    count_bits(1024, ones, trans, perr);
    chk(ones >= 756 && ones <= 780, "R1 held sample without strobe", ones, 768);
    load(-FS / 2);
    repeat (64) @(negedge clk);
    count_bits(1024, ones, trans, perr);
    chk(ones >= 244 && ones <= 268, "R1 new sample on strobe", ones, 256);
  endtask

  task automatic t_disable();
    int lows;
    do_reset();
    load(0);
    mod_tick = 1'b1;
    lows = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (gates() == 4'b0) lows++;
    end
    chk(lows == 50, "R7 idle gates low", lows, 50);
    run = 1'b1;
    repeat (20) @(negedge clk);
    chk(gates() != 4'b0, "R2 gates active when running", gates(), 1);
    run = 1'b0;
    @(negedge clk);
    chk(gates() == 4'b0, "R7 gates low after run drops", gates(), 0);
  endtask

  task automatic t_stall();
    logic [3:0] snap;
    int moved, ones, trans, perr;
    start_run(0);
    mod_tick = 1'b0;
    repeat (2) @(negedge clk);
    snap = gates();
    moved = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (gates() != snap) moved++;
    end
    chk(moved == 0, "R2 no change without tick", moved, 0);
    mod_tick = 1'b1;
    count_bits(40, ones, trans, perr);
    chk(trans > 0, "R2 switching resumes with tick", trans, 1);
  endtask

  task automatic capture(output logic [39:0] seq);
    do_reset();
    load(FS * 3 / 10);
    run = 1'b1; mod_tick = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      seq[i] = gate_p_hs;
    end
  endtask

  task automatic t_reset_repeat();
    logic [39:0] a, b;
    capture(a);
    start_run(FS - 1);
    repeat (300) @(negedge clk);
    capture(b);
    chk(a == b, "R8 sequence repeats after reset", longint'(b), longint'(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_density(0);
    t_density(FS / 2);
    t_density(-FS / 2);
    t_density(-FS / 4);
    t_fullscale();
    t_hold();
    t_disable();
    t_stall();
    t_reset_repeat();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule